// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit gives a 32-bit processor a 64-bit accumulator and a multiply-add step. The accumulator is kept as two 32-bit halves: an upper half and a lower half. The full value is the upper half placed above the lower half. Software loads either half through a shared write-data bus and reads both halves at all times. A synchronous clear zeroes both halves.

There are two arithmetic forms. The long form multiplies two signed 32-bit operands. The word form multiplies the signed low 16 bits of each operand. In both forms the signed product is added to the 64-bit accumulator.

A saturation flag from the status word changes how overflow is handled, and the two forms treat it differently:
- In the long form, only the upper half is clamped, which limits the accumulator to a 48-bit range.
- In the word form, the unit checks the sum against a 32-bit signed range. On overflow it writes a marker of 1 into the upper half and the clamped limit into the lower half.

The result is registered at the clock edge that samples the start strobe, and a one-cycle done pulse accompanies it.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset both accumulator halves read zero and `done_o` is low.
- R2: With `op_sel_i`=0 (long form), the accepted operation adds the product of `opa_i` and `opb_i`, both signed 32-bit, to the 64-bit accumulator. With `sat_en_i`=0 the sum wraps modulo 2^64 and both halves take the raw sum.
- R3: With `op_sel_i`=1 (word form), only bits 15:0 of each operand are used, as signed 16-bit values. Their product is sign-extended and added to the accumulator, and bits 31:16 of the operands have no effect. With `sat_en_i`=0 the sum wraps modulo 2^64.
- R4: Long form with `sat_en_i`=1:
  - If bit 63 of the 64-bit sum is set, the upper half gets bits 31:16 forced to one and bits 15:0 from the sum.
  - Otherwise the upper half is the sum's upper half ANDed with 0x00007FFF.
  - In both cases the lower half is the raw sum.
- R5: Word form with `sat_en_i`=1:
  - If the signed 64-bit sum is below -2^31, the upper half becomes 1 and the lower half becomes 0x80000000.
  - If the sum is above 2^31-1, the upper half becomes 1 and the lower half becomes 0x7FFFFFFF.
  - Otherwise both halves take the sum unchanged.
- R6: An operation is accepted at a rising edge where `start_i`=1 and no clear or write strobe is high. Its result is visible on the outputs after that edge, and `done_o` is high for exactly the following cycle. In every other cycle `done_o` is low.
- R7: `clr_i` zeroes both halves at the next edge and takes priority over the write strobes and `start_i`. No done pulse follows a start that is overridden this way.
- R8: `hi_we_i` loads `wdata_i` into the upper half and `lo_we_i` loads it into the lower half, each on its own. A write in the same cycle as `start_i` takes priority: the start is dropped and no done pulse follows.
- R9: In a cycle with no clear, write or start, both halves keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one multiply-accumulate |
| op_sel_i | input | 1 | 0 = long form, 1 = word form |
| sat_en_i | input | 1 | Saturation mode flag |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clr_i | input | 1 | Synchronous clear of both halves |
| hi_we_i | input | 1 | Write strobe, upper half |
| lo_we_i | input | 1 | Write strobe, lower half |
| wdata_i | input | 32 | Write data for either half |
| acc_hi_o | output | 32 | Upper accumulator half |
| acc_lo_o | output | 32 | Lower accumulator half |
| done_o | output | 1 | One-cycle pulse after an accepted operation |

## Verification
The main sweep pairs every operand from a set of edge values with every other, in both forms and both saturation settings. The edge values are zero, ±1, the 16-bit limits, the 32-bit limits, and values whose upper bits differ from their low 16 bits. Each operation starts from preloaded accumulators that sit just inside the 48-bit and 32-bit bounds.

The edge products decide separate questions:
- -2^31 times -2^31 gives the largest positive product, which tells a correct 64-bit product from a truncated one.
- Operands with differing upper bits show whether the word form ignores bits 31:16.
- The preloads near the 32-bit bounds push word sums just past either limit, which tells the two clamp directions apart.
- The preloads near the 48-bit bound check the sign-driven mask of the long form.

Random operands then run chained sums without reloading. Directed cycles cover clear and write collisions with a start.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic                    word_form,
  input  logic [DATA_W-1:0]       opa,
  input  logic [DATA_W-1:0]       opb,
  output logic signed [ACC_W-1:0] product
);
  // Sign-extend a full operand to accumulator width.
  function automatic logic signed [ACC_W-1:0] ext_full(input logic [DATA_W-1:0] v);
    return {{DATA_W{v[DATA_W-1]}}, v};
  endfunction

  // Sign-extend the short field of an operand to accumulator width.
  function automatic logic signed [ACC_W-1:0] ext_short(input logic [DATA_W-1:0] v);
    return {{(ACC_W-WORD_W){v[WORD_W-1]}}, v[WORD_W-1:0]};
  endfunction

  logic signed [ACC_W-1:0] long_p;
  logic signed [ACC_W-1:0] short_p;

  always_comb begin
    long_p  = ext_full(opa) * ext_full(opb);
    short_p = ext_short(opa) * ext_short(opb);
    product = word_form ? short_p : long_p;
  end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W,
  localparam int HALF = DATA_W / 2
) (
  input  logic                    word_form,
  input  logic                    sat_en,
  input  logic signed [ACC_W-1:0] sum,
  output logic [DATA_W-1:0]       res_hi,
  output logic [DATA_W-1:0]       res_lo,
  output logic                    evt_long_neg,
  output logic                    evt_word_over,
  output logic                    evt_word_under
);
  localparam logic signed [ACC_W-1:0] WORD_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] WORD_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] FORCE_ONES = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [DATA_W-1:0] KEEP_MASK  = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [DATA_W-1:0] HI_MARK    = DATA_W'(1);

  // Upper-half clamp of the long form, chosen by the sign of the sum.
  function automatic logic [DATA_W-1:0] clamp_long_hi(input logic signed [ACC_W-1:0] s);
    if (s[ACC_W-1]) return s[ACC_W-1:DATA_W] | FORCE_ONES;
    return s[ACC_W-1:DATA_W] & KEEP_MASK;
  endfunction

  logic [DATA_W-1:0] raw_hi;
  logic [DATA_W-1:0] raw_lo;

  always_comb begin
    raw_hi         = sum[ACC_W-1:DATA_W];
    raw_lo         = sum[DATA_W-1:0];
    evt_long_neg   = sat_en && !word_form && sum[ACC_W-1];
    evt_word_over  = sat_en && word_form && (sum > WORD_MAX);
    evt_word_under = sat_en && word_form && (sum < WORD_MIN);
    res_hi = raw_hi;
    res_lo = raw_lo;
    if (sat_en && !word_form) begin
      res_hi = clamp_long_hi(sum);
    end else if (evt_word_over) begin
      res_hi = HI_MARK;
      res_lo = WORD_MAX[DATA_W-1:0];
    end else if (evt_word_under) begin
      res_hi = HI_MARK;
      res_lo = WORD_MIN[DATA_W-1:0];
    end
  end

  always_comb begin
    a_r5_word_clamp_exclusive: assert (!(evt_word_over && evt_word_under));
  end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd,
  input  logic [DATA_W-1:0] nxt_hi,
  input  logic [DATA_W-1:0] nxt_lo,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);
  logic wr_any;
  assign wr_any = hi_we || lo_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (clr) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (wr_any) begin
      if (hi_we) acc_hi <= wdata;
      if (lo_we) acc_lo <= wdata;
    end else if (upd) begin
      acc_hi <= nxt_hi;
      acc_lo <= nxt_lo;
    end
  end

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == '0 && acc_lo == '0));
  a_r8_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hi_we) |=> acc_hi == $past(wdata));
  a_r8_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && lo_we) |=> acc_lo == $past(wdata));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_any && !upd) |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_sel_i,
  input  logic              sat_en_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              clr_i,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  import mac_pkg::*;
  localparam int ACC_W = 2 * DATA_W;

  mac_op_e                 op_kind;
  logic                    is_word;
  logic                    op_fire;
  logic signed [ACC_W-1:0] product;
  logic signed [ACC_W-1:0] sum;
  logic [DATA_W-1:0]       nxt_hi;
  logic [DATA_W-1:0]       nxt_lo;
  logic                    evt_long_neg;
  logic                    evt_word_over;
  logic                    evt_word_under;

  assign op_kind = mac_op_e'(op_sel_i);
  assign is_word = (op_kind == OP_WORD);
  assign op_fire = start_i && !clr_i && !hi_we_i && !lo_we_i;
  assign sum     = $signed({acc_hi_o, acc_lo_o}) + product;

  mac_product #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prod (
    .word_form(is_word),
    .opa      (opa_i),
    .opb      (opb_i),
    .product  (product)
  );

  mac_saturate #(.DATA_W(DATA_W)) u_sat (
    .word_form     (is_word),
    .sat_en        (sat_en_i),
    .sum           (sum),
    .res_hi        (nxt_hi),
    .res_lo        (nxt_lo),
    .evt_long_neg  (evt_long_neg),
    .evt_word_over (evt_word_over),
    .evt_word_under(evt_word_under)
  );

  mac_acc_reg #(.DATA_W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_i),
    .hi_we (hi_we_i),
    .lo_we (lo_we_i),
    .wdata (wdata_i),
    .upd   (op_fire),
    .nxt_hi(nxt_hi),
    .nxt_lo(nxt_lo),
    .acc_hi(acc_hi_o),
    .acc_lo(acc_lo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= op_fire;
  end

  a_r6_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i && !hi_we_i && !lo_we_i) |=> done_o);
  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && !clr_i && !hi_we_i && !lo_we_i) |=> !done_o);
  a_r4_long_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && sat_en_i && !is_word) |=>
      (acc_hi_o[DATA_W-1:DATA_W/2] == '1 || acc_hi_o[DATA_W-1:DATA_W/2-1] == '0));
  a_r4_long_neg_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && evt_long_neg) |=> acc_hi_o[DATA_W-1:DATA_W/2] == '1);
  a_r5_word_clamp_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && (evt_word_over || evt_word_under)) |=> acc_hi_o == DATA_W'(1));
  a_r5_word_over_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && evt_word_over) |=> acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}});
  a_r5_word_under_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && evt_word_under) |=> acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}});
endmodule

// File: tb/tb_mac_sat_unit.sv
module tb_mac_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, op_sel_i = 1'b0, sat_en_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0, wdata_i = '0;
  logic        clr_i = 1'b0, hi_we_i = 1'b0, lo_we_i = 1'b0;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  longint model = 0;

  always #4 clk = ~clk;

  mac_sat_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
    .sat_en_i(sat_en_i), .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i),
    .hi_we_i(hi_we_i), .lo_we_i(lo_we_i), .wdata_i(wdata_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  task automatic check64(input string req, input longint exp);
    total++;
    if ({acc_hi_o, acc_lo_o} !== exp) begin
      bad++;
      $display("FAIL %s acc actual=%h expected=%h", req, {acc_hi_o, acc_lo_o}, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s done actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Reference step computed from R2..R5 with plain integer arithmetic.
  function automatic longint ref_step(input longint acc, input logic [31:0] a,
                                      input logic [31:0] b, input bit word, input bit sat);
    longint p, s;
    longint hi, lo;
    if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else      p = longint'($signed(a)) * longint'($signed(b));
    s = acc + p;
    if (!sat) return s;
    lo = s & 64'hFFFF_FFFF;
    if (!word) begin
      hi = (s >>> 32) & 64'hFFFF_FFFF;
      hi = (s < 0) ? (hi | 64'hFFFF_0000) : (hi & 64'h7FFF);
      return (hi << 32) | lo;
    end
    if (s < -64'sd2147483648) return 64'h0000_0001_8000_0000;
    if (s > 64'sd2147483647)  return 64'h0000_0001_7FFF_FFFF;
    return s;
  endfunction

  task automatic load(input longint v);
    @(negedge clk);
    hi_we_i = 1'b1; wdata_i = v[63:32];
    @(negedge clk);
    hi_we_i = 1'b0; lo_we_i = 1'b1; wdata_i = v[31:0];
    @(negedge clk);
    lo_we_i = 1'b0;
    model = v;
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input bit word, input bit sat);
    string tag;
    tag = word ? (sat ? "R5" : "R3") : (sat ? "R4" : "R2");
    @(negedge clk);
    start_i = 1'b1; opa_i = a; opb_i = b; op_sel_i = word; sat_en_i = sat;
    @(negedge clk);
    start_i = 1'b0;
    model = ref_step(model, a, b, word, sat);
    check64(tag, model);
    check1("R6", done_o, 1'b1);
  endtask

  logic [31:0] edges [8];
  longint      pre [6];
  int          k;

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'hFFFF_FFFF;
    edges[3] = 32'h0000_7FFF; edges[4] = 32'h0000_8000; edges[5] = 32'h8000_0000;
    edges[6] = 32'h7FFF_FFFF; edges[7] = 32'h1234_8001;
    pre[0] = 64'h0;                   pre[1] = 64'h0000_7FFF_FFFF_FF00;
    pre[2] = 64'hFFFF_8000_0000_0100; pre[3] = 64'h0000_0000_7FFF_FFF0;
    pre[4] = 64'hFFFF_FFFF_8000_0010; pre[5] = 64'h7FFF_FFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    check64("R1", 64'h0);
    check1("R1", done_o, 1'b0);
    rst_n = 1'b1;

    // R1..R5 sweep: every edge pair, both forms, both saturation settings.
    k = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 4; m++) begin
          if (k % 3 != 2) load(pre[k % 6]);
          run_op(edges[i], edges[j], m[0], m[1]);
          k++;
        end

    // R3: upper operand bits ignored in word form.
    load(64'h0);
    run_op(32'hABCD_0003, 32'h5555_FFFE, 1'b1, 1'b0);
    check64("R3", 64'hFFFF_FFFF_FFFF_FFFA);

    // R2: largest positive product.
    load(64'h0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    check64("R2", 64'h4000_0000_0000_0000);

    // R6: done drops the following cycle; R9: accumulator holds.
    @(negedge clk);
    check1("R6", done_o, 1'b0);
    repeat (3) @(negedge clk);
    check64("R9", model);

    // Random chained operations.
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) load({$urandom, $urandom});
      run_op($urandom, $urandom, n[0], n[1]);
    end

    // R7: clear beats writes and start.
    @(negedge clk);
    clr_i = 1'b1; hi_we_i = 1'b1; lo_we_i = 1'b1; start_i = 1'b1;
    wdata_i = 32'hDEAD_BEEF; opa_i = 32'h7; opb_i = 32'h9; op_sel_i = 1'b0; sat_en_i = 1'b0;
    @(negedge clk);
    clr_i = 1'b0; hi_we_i = 1'b0; lo_we_i = 1'b0; start_i = 1'b0;
    model = 0;
    check64("R7", 64'h0);
    check1("R7", done_o, 1'b0);

    // R8: upper write with start -> start dropped, lower half kept.
    load(64'h0000_0011_0000_0022);
    @(negedge clk);
    hi_we_i = 1'b1; wdata_i = 32'hCAFE_0001; start_i = 1'b1; opa_i = 32'h3; opb_i = 32'h3;
    @(negedge clk);
    hi_we_i = 1'b0; start_i = 1'b0;
    model = 64'hCAFE_0001_0000_0022;
    check64("R8", model);
    check1("R8", done_o, 1'b0);
    // R8: lower write alone leaves the upper half.
    @(negedge clk);
    lo_we_i = 1'b1; wdata_i = 32'h0BAD_F00D;
    @(negedge clk);
    lo_we_i = 1'b0;
    model = 64'hCAFE_0001_0BAD_F00D;
    check64("R8", model);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule